// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Driver

This block turns two pending-request inputs, one per queue, into activity on a shared 8-line interrupt request bus. Each queue is given a 5-bit interrupt level in a small programmable register, so there are 32 possible levels. The bus carries those 32 levels in four time slots of eight lines each. A 2-bit slot selector from outside names the slot now on the bus. While a queue's request is pending, the block raises the line for that queue's level during the slot that holds that level.

Software writes the level register once at start-up, and can read it back only on a supervisor access. The two queues are independent. When both are pending, their lines are merged with a bitwise OR. No hardware arbitration is done, so two queues set to the same level share one line.

Top module: `irq_level_mux`

## Requirements
- R1: After a synchronous active-low reset, the level register reads 0x0000 and `irq` is 0x00.
- R2: A write with `cs`, `we` and `supv` all high stores `wdata[15:11]` as the queue 1 level and `wdata[10:6]` as the queue 2 level, on that clock edge. A read (`cs` and `supv` high) returns them in the same positions.
- R3: Bits [5:0] of the register are reserved. They always read as zero, whatever was written to them.
- R4: A write with `supv` low leaves the stored levels unchanged.
- R5: `rdata` is zero whenever `cs` or `supv` is low.
- R6: A level L is binary coded (0 to 31). While its queue is pending and `slot_sel` equals L/8, line `irq[L%8]` is high.
- R7: A pending queue drives nothing in any slot other than L/8.
- R8: A queue whose request input is low contributes nothing to `irq`.
- R9: With both queues pending, `irq` is the bitwise OR of what each would drive alone. Equal levels give a single line.
- R10: `irq` is registered. It reflects `slot_sel`, the request inputs and the stored levels as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register select |
| we | input | 1 | Write strobe (qualified by cs) |
| supv | input | 1 | High for a supervisor access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero unless a supervisor select |
| slot_sel | input | 2 | Bus time slot currently presented |
| req_q1 | input | 1 | Queue 1 pending request, active high |
| req_q2 | input | 1 | Queue 2 pending request, active high |
| irq | output | 8 | Registered interrupt request lines, active high |

## Verification
Two functions can land in the same clock edge.

The first is a register write and an interrupt drive. When a supervisor write changes the levels while a request is pending, the edge that stores the new levels must still produce `irq` from the old levels. The new levels must appear one edge later. The bench provokes this by writing new levels with a request held in the matching slot, then comparing `irq` after each of the two edges against values computed from the old and the new level.

The second is the merging of both queues. The full sweep of every level pair covers equal levels and levels in the same slot, and judges the merged lines against the arithmetic OR of the two single-queue expectations.

// File: rtl/irqlvl_pkg.sv
// Package: shared constants and types for the interrupt level driver.
// Assumes a 16-bit register whose level fields are packed from the MSB down.
package irqlvl_pkg;
    localparam int REG_W   = 16;  // register width
    localparam int LVL_W   = 5;   // bits per level field
    localparam int NUM_SRC = 2;   // request sources (queues)
    localparam int BUS_W   = 8;   // interrupt lines per slot
    localparam int SLOT_W  = LVL_W - $clog2(BUS_W); // slot selector width
    localparam int RSV_W   = REG_W - NUM_SRC * LVL_W; // reserved low bits

    typedef logic [LVL_W-1:0] level_t;
    typedef logic [BUS_W-1:0] lines_t;
endpackage

// File: rtl/irqlvl_regfile.sv
// Module: level register with supervisor access gating.
// Field i occupies bits [REG_W-1-i*LVL_W -: LVL_W]; the low RSV_W bits are
// reserved, not stored, and read as zero. Reads are combinational.
module irqlvl_regfile
    import irqlvl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs,
    input  logic                         we,
    input  logic                         supv,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] levels
);
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic                          wr_ok;
    logic                          rd_ok;

    assign wr_ok  = cs && we && supv;
    assign rd_ok  = cs && supv;
    assign levels = lvl_q;

    // Purpose: capture each level field on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_q[i] <= wdata[REG_W-1-i*LVL_W -: LVL_W];
            end
        end
    end

    // Purpose: assemble read data, with reserved bits and denied reads at zero.
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                rdata[REG_W-1-i*LVL_W -: LVL_W] = lvl_q[i];
            end
        end
    end

    // R3: reserved bits never show a one.
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[RSV_W-1:0] == '0);

    // R4: a user-mode write leaves the stored levels alone.
    assert_user_write_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && !supv) |=> $stable(lvl_q));

    // R5: no data leaks out without a supervisor select.
    assert_denied_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && supv) |-> (rdata == '0));

    // R2: a permitted write is visible on the next cycle.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && supv) |=> (lvl_q[0] == $past(wdata[REG_W-1 -: LVL_W])));
endmodule

// File: rtl/irqlvl_decode.sv
// Module: decodes one source's level into the eight lines of the current slot.
// Assumes the upper level bits name the slot and the lower bits the line.
module irqlvl_decode #(
    parameter int LVL_W  = 5,
    parameter int BUS_W  = 8,
    localparam int LINE_W = $clog2(BUS_W),
    localparam int SLOT_W = LVL_W - LINE_W
) (
    input  logic [LVL_W-1:0]  level,
    input  logic              req,
    input  logic [SLOT_W-1:0] slot_sel,
    output logic [BUS_W-1:0]  lines
);
    // Purpose: one comparator per line against {slot, line index}.
    for (genvar k = 0; k < BUS_W; k++) begin : g_line
        assign lines[k] = req && (level == {slot_sel, LINE_W'(k)});
    end
endmodule

// File: rtl/irq_level_mux.sv
// Module: top of the time-multiplexed interrupt level driver.
// Holds the level register, decodes every source for the presented slot,
// ORs the sources together with no priority and registers the bus.
module irq_level_mux
    import irqlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              supv,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              req_q1,
    input  logic              req_q2,
    output logic [BUS_W-1:0]  irq
);
    logic [NUM_SRC-1:0][LVL_W-1:0] levels;
    logic [NUM_SRC-1:0]            req;
    logic [NUM_SRC-1:0][BUS_W-1:0] src_lines;
    logic [BUS_W-1:0]              merged;
    logic [BUS_W-1:0]              irq_q;

    assign req = {req_q2, req_q1};

    irqlvl_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .we     (we),
        .supv   (supv),
        .wdata  (wdata),
        .rdata  (rdata),
        .levels (levels)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irqlvl_decode #(.LVL_W(LVL_W), .BUS_W(BUS_W)) u_dec (
            .level    (levels[s]),
            .req      (req[s]),
            .slot_sel (slot_sel),
            .lines    (src_lines[s])
        );
    end

    // Purpose: merge all sources with a plain OR, no arbitration.
    always_comb begin
        merged = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            merged = merged | src_lines[s];
        end
    end

    // Purpose: register the bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= merged;
    end

    assign irq = irq_q;

    // R8: with no request pending the bus is idle on the next cycle.
    assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (irq == '0));

    // R9: never more lines than there are sources.
    assert_line_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq) <= NUM_SRC);

    // R6: queue 1 alone in its slot drives exactly its line one cycle later.
    assert_q1_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q1 && !req_q2 && slot_sel == levels[0][LVL_W-1 -: SLOT_W])
        |=> (irq == (BUS_W'(1) << $past(levels[0][LVL_W-SLOT_W-1:0]))));

    // R7: queue 1 alone outside its slot drives nothing.
    assert_q1_wrong_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q1 && !req_q2 && slot_sel != levels[0][LVL_W-1 -: SLOT_W])
        |=> (irq == '0));
endmodule

// File: tb/tb_irq_level_mux.sv
// Bench: sweeps all level pairs, slots and request combinations.
module tb_irq_level_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0, supv = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  slot_sel = '0;
    logic        req_q1 = 1'b0, req_q2 = 1'b0;
    logic [7:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_level_mux dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .supv(supv),
        .wdata(wdata), .rdata(rdata), .slot_sel(slot_sel),
        .req_q1(req_q1), .req_q2(req_q2), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_irq(int l1, int l2, bit r1, bit r2, int slot);
        logic [7:0] e = '0;
        if (r1 && (l1 / 8) == slot) e[l1 % 8] = 1'b1;
        if (r2 && (l2 / 8) == slot) e[l2 % 8] = 1'b1;
        return e;
    endfunction

    task automatic reg_write(input logic [15:0] d, input bit sup);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; supv = sup; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; supv = 1'b0;
    endtask

    task automatic reg_read(input bit sup, output logic [15:0] d);
        cs = 1'b1; we = 1'b0; supv = sup;
        #1 d = rdata;
        cs = 1'b0; supv = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(irq == 8'h00, "R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(1'b1, rd);
        check(rd == 16'h0000, "R1 register after reset", rd, 0);

        // R2, R3: supervisor write and readback, reserved bits dropped
        reg_write(16'hFFFF, 1'b1);
        reg_read(1'b1, rd);
        check(rd == 16'hFFC0, "R2/R3 readback of all-ones write", rd, 16'hFFC0);
        check(rd[5:0] == 6'd0, "R3 reserved bits zero", rd[5:0], 0);
        reg_write({5'd19, 5'd6, 6'h2A}, 1'b1);
        reg_read(1'b1, rd);
        check(rd == {5'd19, 5'd6, 6'h00}, "R2 field positions", rd, {5'd19, 5'd6, 6'h00});

        // R5: denied reads return zero
        reg_read(1'b0, rd);
        check(rd == 16'h0, "R5 user read", rd, 0);
        cs = 1'b0; supv = 1'b1; #1;
        check(rdata == 16'h0, "R5 read without select", rdata, 0);
        supv = 1'b0;

        // R4: user write ignored
        reg_write(16'h0000, 1'b0);
        reg_read(1'b1, rd);
        check(rd == {5'd19, 5'd6, 6'h00}, "R4 user write ignored", rd, {5'd19, 5'd6, 6'h00});

        // R10: latency; queue1 level 19 -> slot 2 line 3
        @(negedge clk);
        slot_sel = 2'd2; req_q1 = 1'b1; req_q2 = 1'b0;
        #1 check(irq == 8'h00, "R10 no change before edge", irq, 0);
        @(negedge clk);
        check(irq == 8'h08, "R10 change after one edge", irq, 8'h08);

        // R10 with a write on the same edge: old level drives first
        cs = 1'b1; we = 1'b1; supv = 1'b1; wdata = {5'd21, 5'd0, 6'h0};
        @(negedge clk);
        cs = 1'b0; we = 1'b0; supv = 1'b0;
        check(irq == 8'h08, "R10 old level on write edge", irq, 8'h08);
        @(negedge clk);
        check(irq == 8'h20, "R10 new level next edge", irq, 8'h20);
        req_q1 = 1'b0;

        // R6..R9: full sweep
        for (int l1 = 0; l1 < 32; l1++) begin
            for (int l2 = 0; l2 < 32; l2++) begin
                reg_write({l1[4:0], l2[4:0], 6'h0}, 1'b1);
                for (int rq = 0; rq < 4; rq++) begin
                    for (int s = 0; s < 4; s++) begin
                        slot_sel = s[1:0]; req_q1 = rq[0]; req_q2 = rq[1];
                        @(negedge clk);
                        e = expect_irq(l1, l2, rq[0], rq[1], s);
                        if (rq == 0)
                            check(irq == e, "R8 no request", irq, e);
                        else if (rq == 3)
                            check(irq == e, "R9 merged sources", irq, e);
                        else if ((((rq == 1) ? l1 : l2) / 8) == s)
                            check(irq == e, "R6 matching slot", irq, e);
                        else
                            check(irq == e, "R7 other slot", irq, e);
                    end
                end
            end
        end
        req_q1 = 1'b0; req_q2 = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule